// File: doc/BRIEF.md
# Direction-Locking Open-Drain Repeater Channel

This block is a cycle-level digital model of a single channel of a bidirectional open-drain bus repeater. A chip uses one copy for the data wire and a second copy for the clock wire. Both copies run on their own, so the two wires may carry lows in opposite directions at the same moment. Each copy has two symmetric sides, A and B. Each side gives the block a sampled, already-synchronised line level, and the block gives each side an active-low pull-down enable. Neither side is fixed as the input or the output.

When an external device pulls one side low, the channel claims a direction for that side. It then pulls the other side low, with a fixed one-cycle registered delay, and holds that pull until the originating side lets go. The low that the channel creates on the far side is never treated as a new source, so the two pull-downs can never hold each other on. Once both sides read high, the lock clears.

At that moment the channel also fires a rise-assist pulse of fixed width on both sides together, provided the assist is enabled. While the pulse runs, the two sides are decoupled. A connection-enable input isolates the two sides entirely when it is low.

Top module: `odr_repeater_chan`

## Requirements
- R1: While rst_n is low at a clock edge, after that edge both pull-down enables read 1 (released) and both assist outputs read 0, whatever the line levels are.
- R2: With conn_en=1 and no lock held, a 0 sampled on a_in gives b_pd_n=0 after the same clock edge. The pull stays on while a_in stays 0 and is released after the first edge that samples a_in=1. a_pd_n stays 1 throughout.
- R3: In the mirror case, a 0 sampled on b_in first gives a_pd_n=0 one edge later, held until b_in returns to 1, with b_pd_n staying 1.
- R4: While side A holds the lock, the low that the channel itself drives onto side B never causes a_pd_n=0. The two pull-down enables are never 0 at the same time.
- R5: If a_in and b_in are both first sampled at 0 on the same edge, side A wins the lock: b_pd_n=0 and a_pd_n=1.
- R6: The lock clears only on an edge that samples both a_in=1 and b_in=1. If the originating side releases while the other side is still held low externally, no pull-down is driven in either direction.
- R7: With accel_en=1, the edge on which a held lock sees both sides high starts a pulse on a_assist and b_assist together. The pulse lasts exactly PULSE_CYC cycles, starting right after that edge, and the two assist outputs are always equal.
- R8: With accel_en=0, no assist pulse occurs and mirroring works unchanged. Clearing accel_en also ends a running pulse after the next edge.
- R9: While the assist pulse runs, no new lock is taken and neither pull-down is driven. A low that is still present after the pulse ends is mirrored one edge after the first edge that sees the pulse finished.
- R10: With conn_en=0, after the next edge both pull-down enables read 1, the assist outputs read 0 and any lock is dropped. A lock dropped this way does not produce an assist pulse when the lines later return high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conn_en | input | 1 | 1 = connection established, 0 = sides isolated |
| accel_en | input | 1 | 1 = rise-assist pulse allowed |
| a_in | input | 1 | Sampled level of side A (1 = high) |
| b_in | input | 1 | Sampled level of side B (1 = high) |
| a_pd_n | output | 1 | Side A pull-down enable, 0 = pull low |
| b_pd_n | output | 1 | Side B pull-down enable, 0 = pull low |
| a_assist | output | 1 | Rise-assist pulse on side A |
| b_assist | output | 1 | Rise-assist pulse on side B |

## Verification
The bench models each wire as the AND of the channel's pull-down and an external open-drain driver, so the channel's own lows come back into it exactly as they would on a real wire.

Several kinds of low are applied, and each one tells apart a different failure:
- A low from side A and a low from side B each check the symmetry of the mirroring.
- A simultaneous low on both sides shows whether the tie-break is fixed.
- A low that is released while the far side is stretched shows whether the lock reverses too early.
- A low that arrives during the assist pulse shows whether the decoupling window is respected.

Disabling the connection or the assist part-way through a transfer shows whether either control leaves a pull or a pulse behind.

// File: rtl/odr_chan_pkg.sv
// Package: shared types for the open-drain repeater channel.
// Assumes: nothing beyond the standard language.
package odr_chan_pkg;

    // Which side currently owns the direction of the channel.
    typedef enum logic [1:0] {
        LOCK_NONE = 2'd0,
        LOCK_A    = 2'd1,
        LOCK_B    = 2'd2
    } lock_e;

endpackage

// File: rtl/odr_dir_lock.sv
// Module: direction lock and registered pull-down drivers.
// What it does: takes a direction from the first side sampled low (side A
//   wins a tie), drives the opposite side low until the owner releases, and
//   clears the lock once both sides read high.
// Assumes: a_in and b_in are synchronised samples of the wired lines, which
//   include this block's own pull-downs.
module odr_dir_lock
    import odr_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conn_en,
    input  logic a_in,
    input  logic b_in,
    input  logic assist_busy,
    output logic a_pd_n,
    output logic b_pd_n,
    output logic lock_freed
);

    lock_e lock_q;
    lock_e lock_d;
    logic  both_high;

    assign both_high  = a_in && b_in;
    // A held lock that sees both lines high has just finished a transfer.
    assign lock_freed = conn_en && (lock_q != LOCK_NONE) && both_high;

    // Purpose: choose the next owner of the direction.
    always_comb begin
        lock_d = lock_q;
        if (!conn_en) begin
            lock_d = LOCK_NONE;
        end else begin
            unique case (lock_q)
                LOCK_NONE: begin
                    if (!assist_busy) begin
                        if (!a_in)      lock_d = LOCK_A;
                        else if (!b_in) lock_d = LOCK_B;
                    end
                end
                LOCK_A, LOCK_B: begin
                    if (both_high) lock_d = LOCK_NONE;
                end
                default: lock_d = LOCK_NONE;
            endcase
        end
    end

    // Purpose: register the owner and the pull-downs it implies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= LOCK_NONE;
            a_pd_n <= 1'b1;
            b_pd_n <= 1'b1;
        end else begin
            lock_q <= lock_d;
            b_pd_n <= !(conn_en && (lock_d == LOCK_A) && !a_in);
            a_pd_n <= !(conn_en && (lock_d == LOCK_B) && !b_in);
        end
    end

endmodule

// File: rtl/odr_assist_timer.sv
// Module: rise-assist one-shot.
// What it does: on a fire request, raises busy for PULSE_CYC cycles; any
//   cycle with conn_en or accel_en low clears it.
// Assumes: PULSE_CYC counts system clock cycles; 0 removes the timer.
module odr_assist_timer #(
    parameter int unsigned PULSE_CYC = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conn_en,
    input  logic accel_en,
    input  logic fire,
    output logic busy
);

    generate
        if (PULSE_CYC == 0) begin : g_none
            assign busy = 1'b0;
        end else begin : g_cnt
            localparam int unsigned CW = $clog2(PULSE_CYC + 1);
            localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);
            logic [CW-1:0] cnt_q;

            // Purpose: load, count down or clear the pulse counter.
            always_ff @(posedge clk) begin
                if (!rst_n || !conn_en || !accel_en) begin
                    cnt_q <= '0;
                end else if (fire) begin
                    cnt_q <= LOAD;
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            assign busy = (cnt_q != '0);
        end
    endgenerate

endmodule

// File: rtl/odr_repeater_chan.sv
// Module: one channel of a direction-locking open-drain repeater.
// What it does: mirrors an external low from either side onto the other
//   side one cycle later, blocks echo, and fires an equal rise-assist pulse
//   on both sides after each release.
// Assumes: line levels are synchronised samples; one instance per wire.
module odr_repeater_chan #(
    parameter int unsigned PULSE_CYC = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conn_en,
    input  logic accel_en,
    input  logic a_in,
    input  logic b_in,
    output logic a_pd_n,
    output logic b_pd_n,
    output logic a_assist,
    output logic b_assist
);

    logic lock_freed;
    logic assist_busy;

    // Direction lock and pull-down registers.
    odr_dir_lock u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .conn_en     (conn_en),
        .a_in        (a_in),
        .b_in        (b_in),
        .assist_busy (assist_busy),
        .a_pd_n      (a_pd_n),
        .b_pd_n      (b_pd_n),
        .lock_freed  (lock_freed)
    );

    // Rise-assist one-shot shared by both sides.
    odr_assist_timer #(.PULSE_CYC(PULSE_CYC)) u_assist (
        .clk      (clk),
        .rst_n    (rst_n),
        .conn_en  (conn_en),
        .accel_en (accel_en),
        .fire     (lock_freed),
        .busy     (assist_busy)
    );

    assign a_assist = assist_busy;
    assign b_assist = assist_busy;

endmodule

// File: rtl/odr_repeater_chan_chk.sv
// Module: property checker bound to odr_repeater_chan.
// What it does: watches the ports for echo, stuck pulls and assist misuse.
// Assumes: the same clock and synchronous reset as the channel.
module odr_repeater_chan_chk (
    input logic clk,
    input logic rst_n,
    input logic conn_en,
    input logic accel_en,
    input logic a_in,
    input logic b_in,
    input logic a_pd_n,
    input logic b_pd_n,
    input logic a_assist,
    input logic b_assist
);

    // R4: the two pull-downs are never on together.
    a_r4_no_dual_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (a_pd_n || b_pd_n));

    // R2: a pull on B persists while A is still low and connected.
    a_r2_hold_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_pd_n && !a_in && conn_en) |=> !b_pd_n);

    // R2: a pull on B drops once A is seen high.
    a_r2_release_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_pd_n && a_in) |=> b_pd_n);

    // R3: a pull on A drops once B is seen high.
    a_r3_release_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_pd_n && b_in) |=> a_pd_n);

    // R7: both sides get the same assist.
    a_r7_equal_assist: assert property (@(posedge clk) disable iff (!rst_n)
        (a_assist == b_assist));

    // R9: no pull-down while the assist pulse runs.
    a_r9_decoupled: assert property (@(posedge clk) disable iff (!rst_n)
        a_assist |-> (a_pd_n && b_pd_n));

    // R8: assist disabled means no pulse after the edge.
    a_r8_no_assist: assert property (@(posedge clk) disable iff (!rst_n)
        !accel_en |=> !a_assist);

    // R10: a dropped connection releases everything.
    a_r10_isolate: assert property (@(posedge clk) disable iff (!rst_n)
        !conn_en |=> (a_pd_n && b_pd_n && !a_assist && !b_assist));

endmodule

bind odr_repeater_chan odr_repeater_chan_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .conn_en  (conn_en),
    .accel_en (accel_en),
    .a_in     (a_in),
    .b_in     (b_in),
    .a_pd_n   (a_pd_n),
    .b_pd_n   (b_pd_n),
    .a_assist (a_assist),
    .b_assist (b_assist)
);

// File: tb/odr_repeater_chan_bench.sv
// Bench: a vector table walked by one loop, then directed tests.
// Each wire is the AND of the channel pull-down and an external driver.
module odr_repeater_chan_bench;

    localparam int unsigned PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conn_en = 1'b1;
    logic accel_en = 1'b1;
    logic a_ext = 1'b1;
    logic b_ext = 1'b1;
    logic a_pd_n, b_pd_n, a_assist, b_assist;
    logic a_line, b_line;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    assign a_line = a_pd_n & a_ext;
    assign b_line = b_pd_n & b_ext;

    odr_repeater_chan #(.PULSE_CYC(PW)) u_odr_repeater_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .conn_en  (conn_en),
        .accel_en (accel_en),
        .a_in     (a_line),
        .b_in     (b_line),
        .a_pd_n   (a_pd_n),
        .b_pd_n   (b_pd_n),
        .a_assist (a_assist),
        .b_assist (b_assist)
    );

    // Row: {conn_en, accel_en, a_ext, b_ext, exp a_pd_n, exp b_pd_n, exp assist}
    localparam int NV = 34;
    localparam logic [6:0] VEC [NV] = '{
        7'b1111_110,  // 0  idle
        7'b1101_100,  // 1  R2 A low mirrored to B
        7'b1101_100,  // 2  R4 echo on B not fed back
        7'b1111_110,  // 3  R2 pull on B released
        7'b1111_111,  // 4  R7 pulse starts
        7'b1111_111,  // 5  R7
        7'b1111_111,  // 6  R7
        7'b1111_111,  // 7  R7 last pulse cycle
        7'b1111_110,  // 8  R7 pulse over
        7'b1110_010,  // 9  R3 B low mirrored to A
        7'b1110_010,  // 10 R3 held
        7'b1111_110,  // 11 R3 released
        7'b1111_111,  // 12 R7
        7'b1111_111,  // 13
        7'b1111_111,  // 14
        7'b1111_111,  // 15
        7'b1111_110,  // 16
        7'b1001_100,  // 17 R8 mirror with assist off
        7'b1011_110,  // 18 R8 release
        7'b1011_110,  // 19 R8 no pulse
        7'b1011_110,  // 20 R8
        7'b1100_100,  // 21 R5 tie, A wins
        7'b1110_110,  // 22 R6 B stretched, no reversal
        7'b1110_110,  // 23 R6
        7'b1111_111,  // 24 R6 lock clears, R7 pulse
        7'b1101_111,  // 25 R9 low during pulse ignored
        7'b1101_111,  // 26 R9
        7'b1101_111,  // 27 R9
        7'b1101_110,  // 28 R9 pulse over, not yet locked
        7'b1101_100,  // 29 R9 now mirrored
        7'b0101_110,  // 30 R10 isolate
        7'b0110_110,  // 31 R10 lows ignored
        7'b1111_110,  // 32 R10 no pulse from dropped lock
        7'b1111_110   // 33
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic ea, input logic eb,
                         input logic es);
        n_chk++;
        if (a_pd_n !== ea || b_pd_n !== eb || a_assist !== es || b_assist !== es) begin
            n_fail++;
            $display("FAIL %s: got a_pd_n=%b b_pd_n=%b a_assist=%b b_assist=%b, expected %b %b %b %b",
                     tag, a_pd_n, b_pd_n, a_assist, b_assist, ea, eb, es, es);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        report();
    end

    initial begin
        // R1: reset state, with side A pulled low externally.
        a_ext = 1'b0;
        repeat (3) step();
        check("R1 reset", 1'b1, 1'b1, 1'b0);
        a_ext = 1'b1;
        step();
        rst_n = 1'b1;
        step();

        for (int i = 0; i < NV; i++) begin
            {conn_en, accel_en, a_ext, b_ext} = VEC[i][6:3];
            step();
            check($sformatf("row %0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R1: reset in the middle of a lock releases the pull.
        a_ext = 1'b0;
        step();
        check("R2 lock before reset", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b0;
        step();
        check("R1 reset mid-lock", 1'b1, 1'b1, 1'b0);
        a_ext = 1'b1;
        rst_n = 1'b1;
        step();
        step();
        check("R1 no pulse after reset", 1'b1, 1'b1, 1'b0);

        // R10: disconnect during a running pulse ends it.
        b_ext = 1'b0;
        step();
        b_ext = 1'b1;
        step();
        step();
        check("R7 pulse running", 1'b1, 1'b1, 1'b1);
        conn_en = 1'b0;
        step();
        check("R10 pulse cut", 1'b1, 1'b1, 1'b0);
        conn_en = 1'b1;
        step();

        // R8: clearing accel_en cuts a running pulse.
        a_ext = 1'b0;
        step();
        a_ext = 1'b1;
        step();
        step();
        check("R7 second pulse", 1'b1, 1'b1, 1'b1);
        accel_en = 1'b0;
        step();
        check("R8 pulse cut", 1'b1, 1'b1, 1'b0);

        report();
    end

endmodule